// File: doc/BRIEF.md
# Effective Address Generator

This unit turns an addressing-mode code, a set of register values and an 8-bit displacement into a 32-bit effective address for a 32-bit RISC core. Four of its modes are pure arithmetic:
- an index register added to a global base register;
- a word-sized PC-relative data access;
- a longword-sized PC-relative data access with the PC aligned down;
- a PC-relative branch target with a signed displacement.

The fifth mode goes through a table. It adds a scaled displacement to a table base register, reads one 32-bit word from memory at that address, and returns that word as the final address.

The core pulses `start` with the operands valid in the same cycle. Arithmetic modes answer with a one-cycle `done` in the next cycle. The table mode raises a one-cycle memory request and holds `busy` until the read data comes back. It then reports `done` one cycle later. Unused mode codes complete at once with an error flag.

Top module: `eagen_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `done`, `err`, `busy` and `mem_req` are low and `ea_out` is zero.
- R2: Mode code 0: in the cycle after `start` is sampled, `done` is high and `ea_out` equals `gbr + r0` modulo 2^32.
- R3: Mode code 1: in the cycle after `start`, `done` is high and `ea_out` equals `pc + zero_extend(disp) * 2` modulo 2^32.
- R4: Mode code 2: in the cycle after `start`, `done` is high and `ea_out` equals `(pc & 32'hFFFF_FFFC) + zero_extend(disp) * 4` modulo 2^32.
- R5: Mode code 3: in the cycle after `start`, `done` is high and `ea_out` equals `pc + sign_extend(disp) * 2` modulo 2^32, where `disp[7]` is the sign.
- R6: Mode code 4: in the cycle after `start`, `mem_req` is high for exactly one cycle with `mem_addr = tbr + zero_extend(disp) * 4`. `busy` is high from that cycle until `mem_valid` is sampled high. In the following cycle `done` is high, `busy` is low and `ea_out` equals the `mem_rdata` sampled with `mem_valid`.
- R7: Mode codes 5, 6 and 7: in the cycle after `start`, `done` and `err` are both high and `ea_out` is zero. `err` is never high without `done`.
- R8: A `start` sampled while `busy` is high is ignored: it produces no `done`, no request, and no change to `ea_out`.
- R9: `mem_valid` sampled while `busy` is low is ignored: `ea_out` and `done` do not change.
- R10: `done` is high for exactly one cycle per accepted request. `ea_out` holds its last value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse; operands valid in the same cycle |
| mode | input | 3 | Addressing-mode code |
| r0 | input | 32 | Index register value |
| gbr | input | 32 | Global base register value |
| tbr | input | 32 | Table base register value |
| pc | input | 32 | Program counter value |
| disp | input | 8 | Displacement field |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Unused mode code, valid with done |
| busy | output | 1 | Table read in flight |
| ea_out | output | 32 | Effective address result |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Read address, valid with mem_req |
| mem_rdata | input | 32 | Read data |
| mem_valid | input | 1 | Read data valid |

## Verification
The bench aims at the following cases, and what each bug would produce:
- Displacement 0x80 in branch mode. Treating it as unsigned would send the branch 256 bytes forward instead of back.
- Displacement 0xFF in the data modes. Sign-extending it would make the address wrap below the PC.
- A PC with its low bits set in longword mode. A missing mask would show up as an unaligned result.
- Operand sums that carry out of bit 31. These expose any extra bit that leaks into the result.
- Table reads answered in the request cycle and after several wait cycles. A new `start` issued during the wait, and a stray `mem_valid` while idle, catch a controller that either restarts or latches data it was not waiting for.

// File: rtl/eagen_pkg.sv
package eagen_pkg;

    parameter int unsigned AW = 32;
    parameter int unsigned DW = 8;

    typedef enum logic [2:0] {
        M_GBR_IDX  = 3'd0,
        M_PC_WORD  = 3'd1,
        M_PC_LONG  = 3'd2,
        M_PC_BRA   = 3'd3,
        M_TBR_DBL  = 3'd4
    } ea_mode_e;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          legal;
        logic          indirect;
    } ea_calc_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } ea_state_e;

    function automatic logic [AW-1:0] zext(input logic [DW-1:0] d);
        return {{(AW-DW){1'b0}}, d};
    endfunction

    function automatic logic [AW-1:0] sext(input logic [DW-1:0] d);
        return {{(AW-DW){d[DW-1]}}, d};
    endfunction

endpackage

// File: rtl/ea_calc.sv
module ea_calc
    import eagen_pkg::*;
(
    input  logic [2:0]    mode,
    input  logic [AW-1:0] r0,
    input  logic [AW-1:0] gbr,
    input  logic [AW-1:0] tbr,
    input  logic [AW-1:0] pc,
    input  logic [DW-1:0] disp,
    output ea_calc_t      res
);
    localparam logic [AW-1:0] LONG_MASK = ~{{(AW-2){1'b0}}, 2'b11};

    logic [AW-1:0] dz;
    logic [AW-1:0] ds;

    always_comb begin
        dz = zext(disp);
        ds = sext(disp);
        res.addr     = '0;
        res.legal    = 1'b1;
        res.indirect = 1'b0;
        case (mode)
            M_GBR_IDX: res.addr = gbr + r0;
            M_PC_WORD: res.addr = pc + (dz << 1);
            M_PC_LONG: res.addr = (pc & LONG_MASK) + (dz << 2);
            M_PC_BRA:  res.addr = pc + (ds << 1);
            M_TBR_DBL: begin
                res.addr     = tbr + (dz << 2);
                res.indirect = 1'b1;
            end
            default:   res.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
    import eagen_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  ea_calc_t      res,
    input  logic [AW-1:0] mem_rdata,
    input  logic          mem_valid,
    output logic          done,
    output logic          err,
    output logic          busy,
    output logic [AW-1:0] ea_out,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr
);
    ea_state_e state;

    assign busy = (state == ST_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            done     <= 1'b0;
            err      <= 1'b0;
            mem_req  <= 1'b0;
            mem_addr <= '0;
            ea_out   <= '0;
        end else begin
            done    <= 1'b0;
            err     <= 1'b0;
            mem_req <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (!res.legal) begin
                            done   <= 1'b1;
                            err    <= 1'b1;
                            ea_out <= '0;
                        end else if (res.indirect) begin
                            state    <= ST_WAIT;
                            mem_req  <= 1'b1;
                            mem_addr <= res.addr;
                        end else begin
                            done   <= 1'b1;
                            ea_out <= res.addr;
                        end
                    end
                end
                ST_WAIT: begin
                    if (mem_valid) begin
                        ea_out <= mem_rdata;
                        done   <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6: request only while the table read is in flight
    a_r6_req_in_busy: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    // R6: request lasts one cycle
    a_r6_req_pulse: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R6: completion follows returned data
    a_r6_done_after_valid: assert property (@(posedge clk) disable iff (rst)
        (busy && mem_valid) |=> (done && !busy));

    // R8: waiting state ignores start and holds without completing
    a_r8_wait_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_valid) |=> (busy && !done && $stable(ea_out)));

    // R7: error only alongside completion
    a_r7_err_with_done: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    // R9: stray data while idle changes nothing
    a_r9_idle_valid_ignored: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start && mem_valid) |=> (!done && $stable(ea_out)));
endmodule

// File: rtl/eagen_top.sv
module eagen_top
    import eagen_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [2:0]    mode,
    input  logic [AW-1:0] r0,
    input  logic [AW-1:0] gbr,
    input  logic [AW-1:0] tbr,
    input  logic [AW-1:0] pc,
    input  logic [DW-1:0] disp,
    output logic          done,
    output logic          err,
    output logic          busy,
    output logic [AW-1:0] ea_out,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic [AW-1:0] mem_rdata,
    input  logic          mem_valid
);
    ea_calc_t calc_res;

    ea_calc u_calc (
        .mode (mode),
        .r0   (r0),
        .gbr  (gbr),
        .tbr  (tbr),
        .pc   (pc),
        .disp (disp),
        .res  (calc_res)
    );

    ea_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .res       (calc_res),
        .mem_rdata (mem_rdata),
        .mem_valid (mem_valid),
        .done      (done),
        .err       (err),
        .busy      (busy),
        .ea_out    (ea_out),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr)
    );

    // R10: completion is a single-cycle pulse unless a new request is accepted
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !done);
endmodule

// File: tb/sim_eagen_top.sv
`timescale 1ns/1ps
module sim_eagen_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [2:0]  mode;
    logic [31:0] r0, gbr, tbr, pc;
    logic [7:0]  disp;
    logic        done, err, busy, mem_req;
    logic [31:0] ea_out, mem_addr;
    logic [31:0] mem_rdata;
    logic        mem_valid;

    always #4 clk = ~clk;

    eagen_top u0 (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .r0(r0), .gbr(gbr), .tbr(tbr), .pc(pc), .disp(disp),
        .done(done), .err(err), .busy(busy), .ea_out(ea_out),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_valid(mem_valid)
    );

    int    total = 0;
    int    bad   = 0;
    int    lat   = 0;
    bit    spurious = 0;
    bit    finished = 0;
    string tag = "R1";

    // reference model state
    bit          e_done, e_err, e_busy, e_req, e_prev_done;
    logic [31:0] e_ea, e_addr;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // behavioural model, advanced on every rising edge
    always @(posedge clk) begin
        if (rst) begin
            e_done = 0; e_err = 0; e_busy = 0; e_req = 0;
            e_ea = 32'h0; e_addr = 32'h0; e_prev_done = 0;
            tag = "R1";
        end else begin
            e_prev_done = e_done;
            e_done = 0; e_err = 0; e_req = 0;
            if (e_busy) begin
                if (start) tag = "R8";          // ignored start during wait
                if (mem_valid) begin
                    e_ea = mem_rdata; e_done = 1; e_busy = 0;
                end
            end else if (start) begin
                case (mode)
                    3'd0: begin e_ea = gbr + r0; e_done = 1; tag = "R2"; end
                    3'd1: begin e_ea = pc + 32'(int'(disp) * 2); e_done = 1; tag = "R3"; end
                    3'd2: begin e_ea = {pc[31:2], 2'b00} + 32'(int'(disp) * 4); e_done = 1; tag = "R4"; end
                    3'd3: begin e_ea = pc + 32'(int'($signed(disp)) * 2); e_done = 1; tag = "R5"; end
                    3'd4: begin e_busy = 1; e_req = 1; e_addr = tbr + 32'(int'(disp) * 4); tag = "R6"; end
                    default: begin e_done = 1; e_err = 1; e_ea = 32'h0; tag = "R7"; end
                endcase
            end else if (mem_valid) begin
                tag = "R9";                     // stray data while idle
            end else if (e_prev_done) begin
                tag = "R10";                    // pulse must have ended
            end
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (!finished) begin
            chk(tag, "done",   {31'b0, done},    {31'b0, e_done});
            chk(tag, "err",    {31'b0, err},     {31'b0, e_err});
            chk(tag, "busy",   {31'b0, busy},    {31'b0, e_busy});
            chk(tag, "mem_req",{31'b0, mem_req}, {31'b0, e_req});
            chk(tag, "ea_out", ea_out, e_ea);
            if (e_req) chk("R6", "mem_addr", mem_addr, e_addr);
        end
    end

    // memory responder
    int          cnt = 0;
    bit          pend = 0;
    logic [31:0] addr_l = 32'h0;
    function automatic logic [31:0] memword(input logic [31:0] a);
        return {a[15:0], ~a[31:16]} ^ 32'h5A3C_0F96;
    endfunction
    always @(negedge clk) begin
        mem_valid = 1'b0;
        if (pend) begin
            if (cnt == 0) begin
                mem_valid = 1'b1; mem_rdata = memword(addr_l); pend = 0;
            end else cnt--;
        end else if (mem_req) begin
            addr_l = mem_addr;
            if (lat == 0) begin
                mem_valid = 1'b1; mem_rdata = memword(mem_addr);
            end else begin
                cnt = lat - 1; pend = 1;
            end
        end else if (spurious) begin
            mem_valid = 1'b1; mem_rdata = 32'hDEAD_BEEF; spurious = 0;
        end
    end

    task automatic go(input logic [2:0] m, input logic [31:0] a0, input logic [31:0] g,
                      input logic [31:0] t, input logic [31:0] p, input logic [7:0] d);
        @(negedge clk);
        start = 1; mode = m; r0 = a0; gbr = g; tbr = t; pc = p; disp = d;
        @(negedge clk);
        start = 0;
        while (e_busy || pend) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst = 1; start = 0; mode = 0; r0 = 0; gbr = 0; tbr = 0; pc = 0; disp = 0;
        mem_rdata = 0; mem_valid = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 checked by the compare block during and after reset
        @(negedge clk);
        // R2 with carry out of bit 31
        go(3'd0, 32'h0000_0010, 32'h1000_0000, 0, 0, 8'h00);
        go(3'd0, 32'h8000_0004, 32'h8000_0000, 0, 0, 8'h00);
        // R3 with largest unsigned displacement
        go(3'd1, 0, 0, 0, 32'h0000_1000, 8'hFF);
        go(3'd1, 0, 0, 0, 32'hFFFF_FF00, 8'h90);
        // R4 with unaligned PC
        go(3'd2, 0, 0, 0, 32'h0000_2003, 8'h01);
        go(3'd2, 0, 0, 0, 32'h0000_2002, 8'hFF);
        // R5 with negative and positive extremes
        go(3'd3, 0, 0, 0, 32'h0000_4000, 8'h80);
        go(3'd3, 0, 0, 0, 32'h0000_4000, 8'h7F);
        go(3'd3, 0, 0, 0, 32'h0000_0002, 8'hFE);
        // R6 at several latencies
        lat = 0; go(3'd4, 0, 0, 32'h0001_0000, 0, 8'h10);
        lat = 3; go(3'd4, 0, 0, 32'hFFFF_FFF0, 0, 8'hFF);
        // R7 unused codes
        go(3'd5, 0, 0, 0, 0, 0);
        go(3'd6, 0, 0, 0, 0, 0);
        go(3'd7, 0, 0, 0, 0, 0);
        // R8 start during a table read
        lat = 5;
        @(negedge clk);
        start = 1; mode = 3'd4; tbr = 32'h0000_8000; disp = 8'h04;
        @(negedge clk);
        start = 0;
        @(negedge clk);
        start = 1; mode = 3'd0; gbr = 32'h1111_1111; r0 = 32'h1;
        @(negedge clk);
        start = 0;
        while (e_busy || pend) @(negedge clk);
        repeat (2) @(negedge clk);
        // R9 stray memory data while idle
        spurious = 1;
        repeat (3) @(negedge clk);
        // R10 back-to-back single-step requests
        @(negedge clk);
        start = 1; mode = 3'd0; gbr = 32'h100; r0 = 32'h1;
        @(negedge clk);
        mode = 3'd1; pc = 32'h200; disp = 8'h3;
        @(negedge clk);
        start = 0;
        repeat (3) @(negedge clk);
        // mixed random traffic
        for (int i = 0; i < 300; i++) begin
            lat = $urandom % 4;
            if ($urandom % 8 == 0) spurious = 1;
            go(3'($urandom % 8), $urandom, $urandom, $urandom, $urandom, 8'($urandom));
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog run did not end actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule